// File: doc/BRIEF.md
# Folding Max-Log Soft Demapper for One PAM Axis

This block turns one received amplitude axis of a square QAM symbol into a vector of per-bit log-likelihood ratios. Two copies serve a full symbol, one fed the in-phase value and one the quadrature value. Both axes are treated as independent pulse-amplitude signals whose levels sit at odd multiples of a half-spacing `D_UNIT`. The axis labels follow a binary-reflected Gray code: bit 0 is the sign bit, and each later bit splits the folded magnitude at its midpoint.

The block does not search every level. It folds the received value once per bit. Each fold subtracts the magnitude of the previous folded value from a scale that halves at each step. The folded values give two quantities for every bit. One is the squared distance to the nearest level that carries the opposite label bit. The other is the squared distance to the nearest level overall. Half their difference, signed so that a positive result favours a label bit of 0, is the LLR with unit noise variance. The number of bits per axis is picked per sample at run time. The pipeline has one folding stage per possible bit and an output register, so the latency is the same for every mode.

Top module: `pam_llr_demapper`

## Requirements
- R1: `out_valid` rises exactly `MAX_BITS`+1 clock cycles (5 with defaults) after a cycle with `in_valid` high, whatever the mode. Samples may arrive on every cycle, and each valid input gives exactly one valid output.
- R2: `in_mode` holds m-1, where m is the number of bits per axis (code 0 gives 1 bit, code 3 gives 4 bits). It is captured together with its sample. The folded values are y0 = `in_axis` and ys = `D_UNIT`·2^(m-s) - |y(s-1)| for s = 1 to m.
- R3: For each bit i < m, the far term is F = (`D_UNIT` + |yi|)^2 and the near term is N = ym^2. The LLR is floor(σ·(F - N)/2), where σ = -1 if yi ≥ 0 and σ = +1 otherwise.
- R4: The LLR of bit i is never positive when yi ≥ 0 and never negative when yi < 0. A positive LLR favours label bit 0. Bit 0 is 1 for a non-negative axis value.
- R5: The LLR of bit i sits at `out_llr[i*LLR_W +: LLR_W]` as a two's complement number. Fields with i ≥ m are zero.
- R6: Each LLR saturates symmetrically to ±(2^(`LLR_W`-1) - 1). The most negative code never appears.
- R7: A synchronous active-low reset clears `out_valid` and `out_llr` to zero.
- R8: While `out_valid` is low, `out_llr` holds the last valid result. Inputs presented with `in_valid` low never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on `in_axis` |
| in_axis | input | AXIS_W | Signed axis value in units of the input LSB |
| in_mode | input | MW | Bits per axis minus one |
| out_valid | output | 1 | LLR vector present |
| out_llr | output | MAX_BITS*LLR_W | Signed LLR fields, bit 0 in the lowest field |

## Verification
The hardest cases to reach from the ports are folded values that land exactly on zero at an inner stage, and an LLR whose raw value is odd and negative, where the floor in the halving decides the last bit. Random axis values rarely produce either. The stimulus therefore mixes a directed sweep, which puts every mode on its fold thresholds, on level centres and on both rails, with random samples. Half of the random samples are drawn inside the active constellation span, so that inner folds change sign often. Random modes change on consecutive cycles, so each sample must carry its own mode through the pipeline.

// File: rtl/pam_llr_pkg.sv
package pam_llr_pkg;

  function automatic longint mag(longint v);
    return (v < 0) ? -v : v;
  endfunction

  // next folded value from the previous one and the stage scale exponent
  function automatic longint fold_next(longint prev, longint d, int shamt);
    return (d <<< shamt) - mag(prev);
  endfunction

  // unsaturated LLR: far minus near distance, signed by the slice, halved
  function automatic longint llr_raw(longint yi, longint ym, longint d);
    longint far_t;
    longint near_t;
    longint diff;
    far_t  = (d + mag(yi)) * (d + mag(yi));
    near_t = ym * ym;
    diff   = far_t - near_t;
    if (yi >= 0) diff = -diff;
    return diff >>> 1;
  endfunction

  function automatic longint sat_sym(longint v, int w);
    longint lim;
    lim = (longint'(1) <<< (w - 1)) - 1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/pam_fold_stage.sv
module pam_fold_stage
  import pam_llr_pkg::*;
#(
  parameter int SW       = 18,
  parameter int MAX_BITS = 4,
  parameter int MW       = 2,
  parameter int S        = 1,
  parameter int D_UNIT   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic [MW-1:0]            mode_i,
  input  logic signed [SW-1:0]     tail_i,
  input  logic [MAX_BITS*SW-1:0]   ys_i,
  output logic                     vld_o,
  output logic [MW-1:0]            mode_o,
  output logic signed [SW-1:0]     tail_o,
  output logic [MAX_BITS*SW-1:0]   ys_o
);

  logic                   stage_act;
  int                     sh;
  logic signed [SW-1:0]   scale;
  logic signed [SW-1:0]   fold_val;
  logic signed [SW-1:0]   nxt_tail;
  logic [MAX_BITS*SW-1:0] nxt_ys;

  always_comb begin
    stage_act = (int'(mode_i) + 1) >= S;
    sh        = stage_act ? (int'(mode_i) + 1 - S) : 0;
    scale     = SW'(longint'(D_UNIT) <<< sh);
    fold_val  = SW'(fold_next(longint'(tail_i), longint'(D_UNIT), sh));
    nxt_tail  = stage_act ? fold_val : tail_i;
  end

  generate
    if (S < MAX_BITS) begin : g_store
      always_comb begin
        nxt_ys = ys_i;
        if (stage_act) nxt_ys[S*SW +: SW] = fold_val;
      end
    end else begin : g_pass
      assign nxt_ys = ys_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      mode_o <= '0;
      tail_o <= '0;
      ys_o   <= '0;
    end else begin
      vld_o  <= vld_i;
      mode_o <= mode_i;
      tail_o <= nxt_tail;
      ys_o   <= nxt_ys;
    end
  end

  // R2: an active fold never exceeds its stage scale
  assert_fold_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && stage_act) |=> (tail_o <= $past(scale)));

endmodule

// File: rtl/pam_llr_unit.sv
module pam_llr_unit
  import pam_llr_pkg::*;
#(
  parameter int SW     = 18,
  parameter int LLR_W  = 16,
  parameter int MW     = 2,
  parameter int IDX    = 0,
  parameter int D_UNIT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic [MW-1:0]           mode_i,
  input  logic signed [SW-1:0]    y_i,
  input  logic signed [SW-1:0]    y_near,
  output logic signed [LLR_W-1:0] llr_o
);

  logic   bit_used;
  longint raw;

  always_comb begin
    bit_used = int'(mode_i) >= IDX;
    raw      = llr_raw(longint'(y_i), longint'(y_near), longint'(D_UNIT));
    llr_o    = bit_used ? LLR_W'(sat_sym(raw, LLR_W)) : '0;
  end

  // R4: LLR sign follows the slice sign
  assert_sign_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && bit_used && (y_i >= 0)) |-> (llr_o <= 0));
  assert_sign_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && bit_used && (y_i < 0)) |-> (llr_o >= 0));

endmodule

// File: rtl/pam_llr_demapper.sv
module pam_llr_demapper
  import pam_llr_pkg::*;
#(
  parameter int AXIS_W   = 12,
  parameter int MAX_BITS = 4,
  parameter int LLR_W    = 16,
  parameter int D_UNIT   = 16,
  localparam int MW      = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic signed [AXIS_W-1:0]    in_axis,
  input  logic [MW-1:0]               in_mode,
  output logic                        out_valid,
  output logic [MAX_BITS*LLR_W-1:0]   out_llr
);

  localparam int SW = AXIS_W + MAX_BITS + 2;

  logic                   vld_c  [0:MAX_BITS];
  logic [MW-1:0]          mode_c [0:MAX_BITS];
  logic signed [SW-1:0]   tail_c [0:MAX_BITS];
  logic [MAX_BITS*SW-1:0] ys_c   [0:MAX_BITS];
  logic [MAX_BITS*LLR_W-1:0] llr_nxt;
  logic [MW-1:0]          out_mode_q;

  always_comb begin
    vld_c[0]          = in_valid;
    mode_c[0]         = in_mode;
    tail_c[0]         = SW'(in_axis);
    ys_c[0]           = '0;
    ys_c[0][SW-1:0]   = SW'(in_axis);
  end

  generate
    for (genvar s = 1; s <= MAX_BITS; s++) begin : g_fold
      pam_fold_stage #(
        .SW(SW), .MAX_BITS(MAX_BITS), .MW(MW), .S(s), .D_UNIT(D_UNIT)
      ) stage_i (
        .clk(clk), .rst_n(rst_n),
        .vld_i(vld_c[s-1]), .mode_i(mode_c[s-1]),
        .tail_i(tail_c[s-1]), .ys_i(ys_c[s-1]),
        .vld_o(vld_c[s]), .mode_o(mode_c[s]),
        .tail_o(tail_c[s]), .ys_o(ys_c[s])
      );
    end

    for (genvar i = 0; i < MAX_BITS; i++) begin : g_llr
      pam_llr_unit #(
        .SW(SW), .LLR_W(LLR_W), .MW(MW), .IDX(i), .D_UNIT(D_UNIT)
      ) unit_i (
        .clk(clk), .rst_n(rst_n),
        .vld_i(vld_c[MAX_BITS]), .mode_i(mode_c[MAX_BITS]),
        .y_i(ys_c[MAX_BITS][i*SW +: SW]), .y_near(tail_c[MAX_BITS]),
        .llr_o(llr_nxt[i*LLR_W +: LLR_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_llr    <= '0;
      out_mode_q <= '0;
    end else begin
      out_valid <= vld_c[MAX_BITS];
      if (vld_c[MAX_BITS]) begin
        out_llr    <= llr_nxt;
        out_mode_q <= mode_c[MAX_BITS];
      end
    end
  end

  // R3: the final fold is a nearest-level offset and never exceeds D
  assert_near_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_c[MAX_BITS] |-> (tail_c[MAX_BITS] <= SW'(D_UNIT)));

  generate
    for (genvar i = 0; i < MAX_BITS; i++) begin : g_chk
      // R5: fields above the active bit count are zero
      assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (i > int'(out_mode_q))) |-> (out_llr[i*LLR_W +: LLR_W] == '0));
      // R6: symmetric saturation never yields the most negative code
      assert_no_min_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_llr[i*LLR_W +: LLR_W] != {1'b1, {(LLR_W-1){1'b0}}}));
    end
  endgenerate

endmodule

// File: tb/pam_llr_demapper_tb_top.sv
module pam_llr_demapper_tb_top;
  localparam int AXIS_W = 12, MAX_BITS = 4, LLR_W = 16, D_UNIT = 16, MW = 2;
  localparam int LAT = MAX_BITS + 1;
  localparam int NV  = MAX_BITS * LLR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                     rst_n = 1'b0;
  logic                     in_valid = 1'b0;
  logic signed [AXIS_W-1:0] in_axis = '0;
  logic [MW-1:0]            in_mode = '0;
  logic                     out_valid;
  logic [NV-1:0]            out_llr;

  pam_llr_demapper #(.AXIS_W(AXIS_W), .MAX_BITS(MAX_BITS), .LLR_W(LLR_W), .D_UNIT(D_UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_axis(in_axis),
    .in_mode(in_mode), .out_valid(out_valid), .out_llr(out_llr));

  int checks = 0;
  int fails  = 0;
  bit hv [LAT];
  int ha [LAT];
  int hm [LAT];
  logic [NV-1:0] held = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected LLR of one field, computed by unfolding the level grid
  function automatic longint ref_field(int axis, int mode, int i, output bit clipped);
    longint y [0:MAX_BITS];
    longint m, t, lim, v;
    m = mode + 1;
    clipped = 1'b0;
    if (i >= m) return 0;
    y[0] = axis;
    for (int s = 1; s <= m; s++)
      y[s] = longint'(D_UNIT) * (longint'(1) << (m - s)) - ((y[s-1] < 0) ? -y[s-1] : y[s-1]);
    t = (D_UNIT + ((y[i] < 0) ? -y[i] : y[i]));
    t = t * t - y[m] * y[m];
    if (y[i] >= 0) t = -t;
    v = (t - (t & 1)) / 2;
    lim = (longint'(1) << (LLR_W - 1)) - 1;
    if (v > lim) begin clipped = 1'b1; v = lim; end
    if (v < -lim) begin clipped = 1'b1; v = -lim; end
    return v;
  endfunction

  // one cycle at the falling edge: check what left, then drive next
  task automatic step(bit v, int axis, int mode);
    @(negedge clk);
    check(out_valid == hv[LAT-1], rst_n ? "R1" : "R7", "out_valid", out_valid, hv[LAT-1]);
    if (hv[LAT-1]) begin
      for (int i = 0; i < MAX_BITS; i++) begin
        bit clp;
        longint e, a;
        e = ref_field(ha[LAT-1], hm[LAT-1], i, clp);
        a = longint'($signed(out_llr[i*LLR_W +: LLR_W]));
        if (i > hm[LAT-1]) check(a == e, "R5", "unused field", a, e);
        else if (clp) check(a == e, "R6", "saturated field", a, e);
        else check(a == e, "R2 R3", "llr field", a, e);
        if (i <= hm[LAT-1])
          check((ha[LAT-1] >= 0) == (i == 0 ? (a <= 0) : 1'b1) || i != 0, "R4", "bit0 sign", a, e);
        held[i*LLR_W +: LLR_W] = LLR_W'(e);
      end
    end else begin
      check(out_llr == held, rst_n ? "R8" : "R7", "held output", longint'(out_llr[31:0]), longint'(held[31:0]));
    end
    for (int k = LAT - 1; k > 0; k--) begin
      hv[k] = hv[k-1]; ha[k] = ha[k-1]; hm[k] = hm[k-1];
    end
    hv[0] = v && rst_n; ha[0] = axis; hm[0] = mode;
    in_valid = v;
    in_axis  = AXIS_W'(axis);
    in_mode  = MW'(mode);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int dir_vals [14] = '{0, 1, -1, 16, -16, 32, 64, 128, -128, 240, -240, 255, 2047, -2048};

  initial begin : main
    void'($urandom(32'd4242));
    for (int k = 0; k < LAT; k++) begin hv[k] = 1'b0; ha[k] = 0; hm[k] = 0; end
    // R7: reset state
    for (int k = 0; k < 4; k++) step(1'b0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed sweep over thresholds, level centres and rails
    for (int md = 0; md < MAX_BITS; md++)
      for (int j = 0; j < 14; j++) step(1'b1, dir_vals[j], md);
    // R8: gap with junk data must not reach the output
    for (int k = 0; k < 8; k++) step(1'b0, 2047 - k, k % MAX_BITS);
    // mixed random traffic, per-sample modes
    for (int n = 0; n < 3000; n++) begin
      int md, ax, span;
      md = int'($urandom_range(MAX_BITS - 1));
      span = D_UNIT * (1 << (md + 1));
      if ($urandom_range(1) == 0) ax = int'($urandom_range(2 * span)) - span;
      else ax = int'($urandom_range(4095)) - 2048;
      step($urandom_range(3) != 0, ax, md);
    end
    for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule